// File: doc/BRIEF.md
# Debounced Pushbutton with Autorepeat

This block conditions one mechanical key. A raw key level that is already synchronised to the clock goes through a three-state settle filter. The first high sample raises the debounced level at once. A fixed settle window then decides whether the press was real. If the key is still high when the window closes, the press is confirmed. If it is low, the level drops again and the press is discarded.

The confirmed press drives a repeat generator. It emits one single-cycle key event when the press is confirmed. It emits a second event after a long initial hold delay, and after that one event per shorter repeat period for as long as the confirmed press lasts. A release stops the events at once. Because the repeat generator only sees the confirmed state, contact bounce on release cannot add events. Constraints on the parameters: DEBOUNCE_CYCLES >= 3, REPEAT_CYCLES >= 2, INITIAL_DELAY_CYCLES > REPEAT_CYCLES.

Top module: `key_repeat_front`

## Requirements
- R1: While reset is asserted, and in the cycle after it, both key_level and key_event are 0.
- R2: With the filter at rest, key_raw sampled high at a clock edge makes key_level 1 from that edge onward (pending state).
- R3: The settle decision is taken at the edge exactly DEBOUNCE_CYCLES edges after the edge that started pending. Values of key_raw at the edges in between are ignored. A low sample at the decision edge returns key_level to 0, and a high sample confirms the press.
- R4: A confirmed press keeps key_level at 1 until key_raw is sampled low. key_level is 0 from that edge.
- R5: The first key_event pulse comes one clock edge after the decision edge that confirmed the press.
- R6: While the press stays confirmed, the second key_event pulse comes INITIAL_DELAY_CYCLES cycles after the first.
- R7: Every later key_event pulse comes REPEAT_CYCLES cycles after the previous one, until release.
- R8: No key_event pulse occurs while the press is not confirmed. This includes the cycle in which a release and a period expiry coincide: the release wins.
- R9: Every key_event pulse lasts exactly one clock cycle.
- R10: A press that is low at its decision edge produces no key_event at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_raw | input | 1 | Synchronised raw key level, 1 = pressed |
| key_level | output | 1 | Debounced key level |
| key_event | output | 1 | Single-cycle pulse for each press or repeat |

## Verification
A release and a repeat-period expiry can land on the same edge of the repeat generator. In that case the release must suppress the pulse. The bench provokes this with a sweep of hold lengths across one full repeat period beyond the initial delay, plus random hold lengths. In every cycle it compares the pulse against a reference model that first applies the release and only then evaluates the timing.

// File: rtl/krp_pkg.sv
package krp_pkg;

    typedef enum logic [1:0] {
        DB_REST    = 2'd0,
        DB_PENDING = 2'd1,
        DB_CONFIRM = 2'd2
    } db_state_e;

    typedef enum logic [1:0] {
        RP_REST    = 2'd0,
        RP_INITIAL = 2'd1,
        RP_PHASE_A = 2'd2,
        RP_PHASE_B = 2'd3
    } rp_state_e;

endpackage

// File: rtl/krp_settle_timer.sv
module krp_settle_timer #(
    parameter int unsigned LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run) begin
            t_d.cnt  = '0;
            t_d.done = 1'b0;
        end else if (t_q.cnt < CW'(LIMIT)) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end else begin
            t_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired = t_q.done;

    // R3: the window restarts from zero each time it is switched off
    a_r3_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired);

endmodule

// File: rtl/krp_debounce_fsm.sv
module krp_debounce_fsm
    import krp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key,
    input  logic expired,
    output logic timer_run,
    output logic level,
    output logic confirmed
);
    typedef struct packed {
        db_state_e state;
    } db_t;

    db_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            DB_REST:    if (key) s_d.state = DB_PENDING;
            DB_PENDING: if (expired) s_d.state = key ? DB_CONFIRM : DB_REST;
            DB_CONFIRM: if (!key) s_d.state = DB_REST;
            default:    s_d.state = DB_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: DB_REST};
        else        s_q <= s_d;
    end

    assign timer_run = (s_q.state == DB_PENDING);
    assign level     = (s_q.state != DB_REST);
    assign confirmed = (s_q.state == DB_CONFIRM);

    // R3: pending is left only when the settle window has closed
    a_r3_pending_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_run && !expired) |=> timer_run);
    // R4: a confirmed press survives as long as the key stays high
    a_r4_confirm_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (confirmed && key) |=> confirmed);
    // R2: a released key leaves the filter at rest
    a_r2_rest_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && !key) |=> !level);

endmodule

// File: rtl/krp_repeat_gen.sv
module krp_repeat_gen
    import krp_pkg::*;
#(
    parameter int unsigned INIT_CYCLES   = 500,
    parameter int unsigned PERIOD_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic held,
    output logic pulse
);
    localparam int unsigned CW = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        rp_state_e     state;
        logic [CW-1:0] cnt;
        logic          pulse;
    } rp_t;

    rp_t r_d, r_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim = (r_q.state == RP_INITIAL) ? CW'(INIT_CYCLES - 1) : CW'(PERIOD_CYCLES - 1);
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (!held) begin
            r_d.state = RP_REST;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                RP_REST: begin
                    r_d.state = RP_INITIAL;
                    r_d.cnt   = '0;
                    r_d.pulse = 1'b1;
                end
                default: begin
                    if (r_q.cnt == lim) begin
                        r_d.cnt   = '0;
                        r_d.pulse = 1'b1;
                        r_d.state = (r_q.state == RP_PHASE_A) ? RP_PHASE_B : RP_PHASE_A;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: RP_REST, cnt: '0, pulse: 1'b0};
        else        r_q <= r_d;
    end

    assign pulse = r_q.pulse;

    // R8: no pulse once the confirmed press is gone
    a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !held |=> !pulse);
    // R5: a fresh confirmation is announced on the next edge
    a_r5_press_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (held && r_q.state == RP_REST) |=> pulse);
    // R9: pulses never run into a second cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/key_repeat_front.sv
module key_repeat_front #(
    parameter int unsigned DEBOUNCE_CYCLES      = 16,
    parameter int unsigned INITIAL_DELAY_CYCLES = 500,
    parameter int unsigned REPEAT_CYCLES        = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_raw,
    output logic key_level,
    output logic key_event
);
    localparam int unsigned SETTLE_LIMIT = DEBOUNCE_CYCLES - 2;

    logic timer_run, expired, confirmed;

    krp_settle_timer #(.LIMIT(SETTLE_LIMIT)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .expired (expired)
    );

    krp_debounce_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .key       (key_raw),
        .expired   (expired),
        .timer_run (timer_run),
        .level     (key_level),
        .confirmed (confirmed)
    );

    krp_repeat_gen #(
        .INIT_CYCLES   (INITIAL_DELAY_CYCLES),
        .PERIOD_CYCLES (REPEAT_CYCLES)
    ) rep_i (
        .clk   (clk),
        .rst_n (rst_n),
        .held  (confirmed),
        .pulse (key_event)
    );

    // R4: a press cannot be confirmed while the key level reads low
    a_r4_level_covers: assert property (@(posedge clk) disable iff (!rst_n)
        key_event |-> key_level || $fell(key_level));

endmodule

// File: tb/key_repeat_front_tb_top.sv
module key_repeat_front_tb_top;
    localparam int D = 8;
    localparam int I = 20;
    localparam int R = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_raw = 1'b0;
    logic key_level, key_event;

    int total = 0;
    int bad = 0;
    bit checking = 0;
    int ev_seen = 0;

    // reference model state
    int rs = 0, pc = 0, rr = 0, rc = 0, kind = 0;
    bit exp_ev = 0, conf_prev = 0;

    always #2.5 clk = ~clk;

    key_repeat_front #(
        .DEBOUNCE_CYCLES      (D),
        .INITIAL_DELAY_CYCLES (I),
        .REPEAT_CYCLES        (R)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_raw   (key_raw),
        .key_level (key_level),
        .key_event (key_event)
    );

    task automatic chk(input string tag, input logic act, input logic exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp_v);
        end
    endtask

    function automatic int lim_for(input int st);
        return (st == 1) ? I : R;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs = 0; pc = 0; rr = 0; rc = 0; exp_ev = 0; kind = 0;
        end else begin
            conf_prev = (rs == 2);
            if (!conf_prev) begin
                rr = 0; exp_ev = 0;
            end else if (rr == 0) begin
                exp_ev = 1; rr = 1; rc = 0; kind = 5;
            end else begin
                rc++;
                if (rc == lim_for(rr)) begin
                    exp_ev = 1; kind = (rr == 1) ? 6 : 7; rr = 2; rc = 0;
                end else exp_ev = 0;
            end
            case (rs)
                0: if (key_raw) begin rs = 1; pc = 0; end
                1: begin pc++; if (pc == D) rs = key_raw ? 2 : 0; end
                default: if (!key_raw) rs = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (checking && rst_n) begin
            if (key_event) ev_seen++;
            chk(rs == 0 ? "R2" : (rs == 1 ? "R3" : "R4"), key_level, rs != 0);
            if (exp_ev) chk(kind == 5 ? "R5" : (kind == 6 ? "R6" : "R7"), key_event, 1'b1);
            else        chk(conf_prev ? "R9" : "R8", key_event, 1'b0);
        end
    end

    task automatic drive(input logic v, input int n);
        key_raw = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expected=finish actual=hang");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1", key_level, 1'b0);
        chk("R1", key_event, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", key_level, 1'b0);
        chk("R1", key_event, 1'b0);
        checking = 1;
        // clean long press with several repeats
        drive(1'b1, 100);
        drive(1'b0, 30);
        // glitch shorter than the window: R10
        base = ev_seen;
        drive(1'b1, 3);
        drive(1'b0, 30);
        total++;
        if (ev_seen != base) begin
            bad++;
            $display("FAIL R10 actual=%0d expected=0", ev_seen - base);
        end
        // bounce inside the window ending high
        drive(1'b1, 1); drive(1'b0, 2); drive(1'b1, 1); drive(1'b0, 1);
        drive(1'b1, 60);
        // bounce on release
        drive(1'b0, 1); drive(1'b1, 1); drive(1'b0, 1); drive(1'b1, 2);
        drive(1'b0, 30);
        // release swept across a repeat expiry: R8
        for (int k = 0; k <= 2 * R; k++) begin
            drive(1'b1, D + I + R + k);
            drive(1'b0, 15);
        end
        // random segments
        for (int s = 0; s < 300; s++) begin
            drive(1'($urandom_range(0, 1)), int'($urandom_range(1, 60)));
        end
        drive(1'b0, 20);
        checking = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule